// File: doc/BRIEF.md
# Input Clock Loss-of-Signal Detector

This block watches one input clock from a free-running reference clock and drives a single flag. The flag reads 1 while the watched clock is absent and 0 while it is present. One instance serves one clock input. A chip with two selectable inputs places two instances, one per input. Control logic can then read both flags before it moves the input selection.

Every rising edge of the watched clock flips a one-bit marker in that clock's own domain. The marker crosses into the reference domain through a short synchronizer chain. Any change seen at the end of the chain counts as activity. A reference-domain counter measures the time since the last activity and raises the flag when the timeout expires, about 15 µs by default. The flag clears as soon as new activity shows up. It does not wait for the counter, so the clear path takes only a few reference cycles, well inside one period of a slow input.

The marker toggles once per watched period. For activity to be seen reliably, the reference clock must run faster than the watched clock.

Top module: `clk_loss_monitor`

## Requirements
- R1: After reset the flag is 1 (clock absent). It stays 1 until the first activity is detected.
- R2: Each rising edge of the watched clock inverts a marker bit. The reference domain samples that bit through a chain of `SYNC_STAGES` registers. A difference between the last stage and its one-cycle-delayed copy counts as activity.
- R3: On the reference edge at which activity is seen, the flag becomes 0, whatever the counter value. With the default two stages, a clock that resumes clears the flag within one period of a 25 MHz input.
- R4: With no further activity, the flag becomes 1 exactly `TIMEOUT_CYCLES = REF_CLK_MHZ * TIMEOUT_US` reference edges after the edge that saw the last activity, and not earlier.
- R5: While the gaps between activity are shorter than the timeout, the flag stays 0. A 1 MHz watched clock is one such case.
- R6: The idle counter saturates. With the watched clock stopped, the flag stays 1 indefinitely and never drops back through counter wrap-around.
- R7: A single isolated rising edge on the watched clock clears the flag. The flag then rises again once the timeout elapses.
- R8: Driving reset low at any time returns the flag to 1. After release, the flag stays 1 until new activity is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Free-running reference clock for the detector |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| monClk | input | 1 | Clock being watched |
| lossFlag | output | 1 | 1 = watched clock absent, 0 = present |

## Verification
If the marker, the synchronizer or its delayed copy holds a wrong value, the falling edge of the flag moves by one or more reference cycles after the watched clock resumes, or the flag never falls at all. That shows at the port within a few cycles. A wrong idle count only shows when the timeout expires: the rising edge of the flag moves away from its exact cycle, up to about 3750 cycles after the clock stops. A wrap-around fault shows as the flag dropping during a long absence. The bench models activity detection and the idle interval per reference edge, and compares the flag on every cycle. A misplaced edge is therefore caught at the first cycle where it differs.

// File: rtl/los_mon_pkg.sv
`timescale 1ns/1ps
package los_mon_pkg;

  // Strobes issued by the control to the idle-time datapath.
  typedef struct packed {
    logic clearCount;    // restart the idle interval
    logic advanceCount;  // one more idle reference cycle
  } losStrobes_t;

  typedef enum logic {
    ST_PRESENT = 1'b0,
    ST_ABSENT  = 1'b1
  } losState_e;

endpackage

// File: rtl/los_mon_datapath.sv
`timescale 1ns/1ps
module los_mon_datapath
  import los_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 12,
  parameter int LIMIT       = 3749
) (
  input  logic        refClk,
  input  logic        monClk,
  input  logic        rstN,
  input  losStrobes_t strobes,
  output logic        activity,
  output logic        countSat
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

  // Watched-domain marker: flips on every rising edge (R2)
  logic togQ;
  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) togQ <= 1'b0;
    else       togQ <= ~togQ;
  end

  // Crossing into the reference domain
  logic [SYNC_STAGES-1:0] syncQ;
  generate
    if (SYNC_STAGES == 1) begin : g_sync_single
      always_ff @(posedge refClk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= togQ;
      end
    end else begin : g_sync_chain
      always_ff @(posedge refClk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], togQ};
      end
    end
  endgenerate

  logic prevQ;
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  assign activity = syncQ[SYNC_STAGES-1] ^ prevQ;

  // Idle-interval counter, saturating at LIMIT (R6)
  logic [CNT_W-1:0] count;
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                     count <= '0;
    else if (strobes.clearCount)   count <= '0;
    else if (strobes.advanceCount) count <= count + 1'b1;
  end

  assign countSat = (count == LIMIT_V);

  // R2: activity restarts the idle interval
  a_r2_restart_after_activity: assert property (@(posedge refClk) disable iff (!rstN)
    activity |=> (count == '0));

  // R6: once saturated with no activity the counter stays put
  a_r6_count_holds_at_limit: assert property (@(posedge refClk) disable iff (!rstN)
    (countSat && !activity) |=> countSat);

endmodule

// File: rtl/los_mon_control.sv
`timescale 1ns/1ps
module los_mon_control
  import los_mon_pkg::*;
(
  input  logic        refClk,
  input  logic        rstN,
  input  logic        activity,
  input  logic        countSat,
  output losStrobes_t strobes,
  output logic        lossFlag
);

  losState_e state, stateNext;

  always_comb begin
    stateNext = state;
    if (activity)      stateNext = ST_PRESENT;  // fast clear path (R3)
    else if (countSat) stateNext = ST_ABSENT;   // timeout (R4)
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) state <= ST_ABSENT;  // R1, R8
    else       state <= stateNext;
  end

  always_comb begin
    strobes.clearCount   = activity;
    strobes.advanceCount = !activity && !countSat;
  end

  assign lossFlag = (state == ST_ABSENT);

  // R3: activity clears the flag on the next edge
  a_r3_clear_on_activity: assert property (@(posedge refClk) disable iff (!rstN)
    activity |=> !lossFlag);

  // R3: the flag falls only because of activity
  a_r3_fall_needs_activity: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(lossFlag) |-> $past(activity));

  // R4: saturated idle count without activity sets the flag
  a_r4_set_on_timeout: assert property (@(posedge refClk) disable iff (!rstN)
    (countSat && !activity) |=> lossFlag);

  // R4: the flag rises only after the full idle interval
  a_r4_rise_needs_timeout: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(lossFlag) |-> $past(countSat));

endmodule

// File: rtl/clk_loss_monitor.sv
`timescale 1ns/1ps
module clk_loss_monitor
  import los_mon_pkg::*;
#(
  parameter int REF_CLK_MHZ = 250,
  parameter int TIMEOUT_US  = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic refClk,
  input  logic rstN,
  input  logic monClk,
  output logic lossFlag
);

  localparam int TIMEOUT_CYCLES = REF_CLK_MHZ * TIMEOUT_US;
  localparam int LIMIT          = TIMEOUT_CYCLES - 1;
  localparam int CNT_W          = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  losStrobes_t strobes;
  logic        activity;
  logic        countSat;

  los_mon_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .CNT_W       (CNT_W),
    .LIMIT       (LIMIT)
  ) datapath_i (
    .refClk   (refClk),
    .monClk   (monClk),
    .rstN     (rstN),
    .strobes  (strobes),
    .activity (activity),
    .countSat (countSat)
  );

  los_mon_control control_i (
    .refClk   (refClk),
    .rstN     (rstN),
    .activity (activity),
    .countSat (countSat),
    .strobes  (strobes),
    .lossFlag (lossFlag)
  );

endmodule

// File: tb/clk_loss_monitor_tb.sv
`timescale 1ns/1ps
module clk_loss_monitor_tb_top;

  localparam int REF_MHZ = 250;
  localparam int TO_US   = 15;
  localparam int SYNC    = 2;
  localparam int T       = REF_MHZ * TO_US;   // idle edges before the flag rises

  logic refClk = 1'b0;
  logic rstN   = 1'b0;
  logic monClk = 1'b0;
  logic lossFlag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  clk_loss_monitor #(
    .REF_CLK_MHZ (REF_MHZ),
    .TIMEOUT_US  (TO_US),
    .SYNC_STAGES (SYNC)
  ) dut_i (
    .refClk   (refClk),
    .rstN     (rstN),
    .monClk   (monClk),
    .lossFlag (lossFlag)
  );

  // 250 MHz reference: rising edges at whole nanoseconds
  always #2 refClk = ~refClk;

  // ---------------- reference model ----------------
  bit monTog;   // flips on each watched rising edge
  always @(posedge monClk or negedge rstN) begin
    if (!rstN) monTog = 1'b0;
    else       monTog = ~monTog;
  end

  bit hist[$];     // hist[0] = sample taken at the previous reference edge
  int idleEdges;
  bit modelFlag = 1'b1;

  always @(posedge refClk) begin
    bit act;
    if (!rstN) begin
      hist = {};
      for (int i = 0; i <= SYNC; i++) hist.push_back(1'b0);
      idleEdges = 0;
      modelFlag = 1'b1;
    end else begin
      act = hist[SYNC-1] ^ hist[SYNC];
      if (act) begin
        idleEdges = 0;
        modelFlag = 1'b0;
      end else begin
        idleEdges++;
        if (idleEdges >= T) modelFlag = 1'b1;
      end
      hist.push_front(monTog);
      void'(hist.pop_back());
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge refClk) begin
    if (rstN && !done) begin
      checks++;
      if (lossFlag !== modelFlag) begin
        errors++;
        $display("FAIL R2/R3/R4 model compare at %0t: actual=%b expected=%b",
                 $time, lossFlag, modelFlag);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // rising edges at half-nanosecond offsets so they never meet a reference edge
  task automatic monPulses(input realtime halfNs, input int n);
    #0.5;
    for (int i = 0; i < n; i++) begin
      monClk = 1'b1;
      #(halfNs);
      monClk = 1'b0;
      #(halfNs);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge refClk);
  endtask

  task automatic measureRise(output int n);
    n = 0;
    while (lossFlag !== 1'b1 && n < 3 * T) begin
      @(negedge refClk);
      n++;
    end
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int riseN;
    rstN = 1'b0;
    waitCycles(3);
    check("R1 flag during reset", lossFlag, 1'b1);
    rstN = 1'b1;
    waitCycles(100);
    check("R1 flag stays set with no clock", lossFlag, 1'b1);

    // 25 MHz watched clock: clear within one input period
    @(negedge refClk);
    monPulses(20.0, 1);
    @(negedge refClk);
    check("R3 clear within one 25 MHz period", lossFlag, 1'b0);
    monPulses(20.0, 30);
    @(negedge refClk);
    check("R2 25 MHz clock keeps flag clear", lossFlag, 1'b0);

    // 1 MHz: gaps well below the timeout
    monPulses(500.0, 20);
    @(negedge refClk);
    check("R5 1 MHz clock keeps flag clear", lossFlag, 1'b0);

    // 125 MHz burst, then stop and time the rise
    monPulses(4.0, 50);
    @(negedge refClk);
    check("R2 125 MHz clock keeps flag clear", lossFlag, 1'b0);
    measureRise(riseN);
    checkRange("R4 rise delay after stop (cycles)", riseN, T - 2, T + SYNC + 2);
    check("R4 flag set after timeout", lossFlag, 1'b1);

    // long absence: no wrap
    waitCycles(2 * T);
    check("R6 flag holds through long absence", lossFlag, 1'b1);

    // single isolated edge
    @(negedge refClk);
    monPulses(3.0, 1);
    waitCycles(SYNC + 3);
    check("R7 single edge clears flag", lossFlag, 1'b0);
    measureRise(riseN);
    checkRange("R7 re-assert delay after single edge", riseN, T - SYNC - 6, T + SYNC + 2);
    check("R7 flag set again", lossFlag, 1'b1);

    // reset in the middle of normal operation
    @(negedge refClk);
    monPulses(3.0, 100);
    @(negedge refClk);
    check("R2 166 MHz clock keeps flag clear", lossFlag, 1'b0);
    rstN = 1'b0;
    @(negedge refClk);
    #1;
    check("R8 reset forces flag", lossFlag, 1'b1);
    @(negedge refClk);
    rstN = 1'b1;
    waitCycles(50);
    check("R8 flag stays set after release", lossFlag, 1'b1);
    @(negedge refClk);
    monPulses(4.0, 5);
    waitCycles(SYNC + 2);
    check("R8 recovery clears flag", lossFlag, 1'b0);

    waitCycles(10);
    finishRun();
  end

  // watchdog
  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      finishRun();
    end
  end

endmodule